// File: doc/BRIEF.md
# Vector Word Permute Unit

This unit rearranges and combines 128-bit vectors made of four 32-bit words. Each transaction presents three operand vectors (A, B and C), a 4-bit operation code and a 2-bit immediate. One clock edge later, the unit returns a registered 128-bit result together with a one-cycle valid strobe. The operations are:

- a doubleword permute, where the immediate picks halves of A and B;
- a word shift-left across the 256-bit concatenation A:B;
- a word splat from B;
- interleaving merges of the high or low word pairs of A and B;
- a per-bit select between A and B, steered by C;
- eight bitwise logical functions of A and B.

An enable input gates the whole unit. A transaction issued while the unit is disabled produces nothing but an unavailable-unit flag. Operation codes with no defined meaning produce an illegal-operation flag. Words are numbered from the most significant end: word 0 of a vector is bits [127:96] and word 3 is bits [31:0]. The high doubleword is words 0 and 1.

Top module: `vperm_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` was high at a rising edge, and is low otherwise. `unavail_exc` and `illegal_op` are never high while `out_valid` is low.
- R2: Every operand is captured at the accepting edge. `result` keeps its value across any cycle with `in_valid` low, whatever the operand inputs do, so a destination that aliases A or B needs no care.
- R3: Codes 0 to 7 give the bitwise functions of A and B. The codes are 0 AND, 1 A AND NOT B, 2 OR, 3 XOR, 4 NOR, 5 XNOR, 6 NAND and 7 A OR NOT B.
- R4: Code 13 gives the per-bit select (B AND C) OR (A AND NOT C).
- R5: Code 8 is the doubleword permute. Immediate bit 1 sends A's high (0) or low (1) doubleword to the result's high doubleword. Immediate bit 0 sends B's high (0) or low (1) doubleword to the result's low doubleword.
- R6: Code 9 is the word shift. With an immediate of k, it returns words k to k+3 of the eight-word concatenation A:B. So k=0 gives A, and k=2 gives A's low doubleword followed by B's high doubleword.
- R7: Code 10 is the splat. The immediate is a word index into B (bit 1 picks the doubleword, bit 0 picks the word within it), and that word fills all four result words.
- R8: Code 11 yields {A.w0, B.w0, A.w1, B.w1} and code 12 yields {A.w2, B.w2, A.w3, B.w3}.
- R9: A transaction accepted with `unit_en` low yields a zero result with `unavail_exc` high and `illegal_op` low, whatever the code.
- R10: Codes 14 and 15, accepted with `unit_en` high, yield a zero result with `illegal_op` high and `unavail_exc` low.
- R11: After reset, `out_valid`, `result`, `unavail_exc` and `illegal_op` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction present this cycle |
| unit_en | input | 1 | Unit enabled; low suppresses the operation |
| op | input | 4 | Operation code |
| imm | input | 2 | Immediate for the permute, shift and splat operations |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| opc | input | 128 | Operand C (select mask) |
| out_valid | output | 1 | Result strobe, one cycle |
| result | output | 128 | Registered result |
| unavail_exc | output | 1 | Transaction issued with the unit disabled |
| illegal_op | output | 1 | Undefined operation code |

## Verification
The bench sweeps every operation code against every immediate value, with the enable both high and low, over a set of patterned and pseudo-random operands. This catches the typical slips:

- Swapping which immediate bit steers A versus B in the permute would put the wrong doublewords in place.
- An off-by-one word index in the shift would break the k=0 identity and the k=2 straddle.
- Confusing the word order within a doubleword would break the splat.
- Interleaving A and B the wrong way round would break the merges.
- Gating with `unit_en` inside the datapath but not on the flags, or the reverse, would leave a stale result or miss the exception.

Between transactions the operand inputs are scrambled while `in_valid` is low. A result register that loads on every cycle, instead of only at acceptance, then shows up as a changed result.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  localparam int LANES = 4;
  localparam int POOL  = 2 * LANES;

  typedef enum logic [3:0] {
    OP_AND    = 4'd0,  OP_ANDC  = 4'd1,  OP_OR    = 4'd2,  OP_XOR   = 4'd3,
    OP_NOR    = 4'd4,  OP_EQV   = 4'd5,  OP_NAND  = 4'd6,  OP_ORC   = 4'd7,
    OP_PERMDW = 4'd8,  OP_SLDW  = 4'd9,  OP_SPLAT = 4'd10, OP_MRGH  = 4'd11,
    OP_MRGL   = 4'd12, OP_SEL   = 4'd13, OP_RSV0  = 4'd14, OP_RSV1  = 4'd15
  } vop_e;

  // one bit of a logical function selected by fn
  function automatic logic bit_fn(input logic [2:0] fn, input logic a, input logic b);
    case (fn)
      3'd0:    bit_fn = a & b;
      3'd1:    bit_fn = a & ~b;
      3'd2:    bit_fn = a | b;
      3'd3:    bit_fn = a ^ b;
      3'd4:    bit_fn = ~(a | b);
      3'd5:    bit_fn = ~(a ^ b);
      3'd6:    bit_fn = ~(a & b);
      default: bit_fn = a | ~b;
    endcase
  endfunction

  // index into the eight-word pool {A.w0..w3, B.w0..w3} for one result lane
  function automatic logic [2:0] src_word(input vop_e op, input logic [1:0] imm,
                                          input logic [1:0] lane);
    case (op)
      OP_PERMDW: src_word = lane[1] ? {1'b1, imm[0], lane[0]} : {1'b0, imm[1], lane[0]};
      OP_SLDW:   src_word = {1'b0, imm} + {1'b0, lane};
      OP_SPLAT:  src_word = {1'b1, imm};
      OP_MRGH:   src_word = {lane[0], 1'b0, lane[1]};
      OP_MRGL:   src_word = {lane[0], 1'b1, lane[1]};
      default:   src_word = 3'd0;
    endcase
  endfunction

  function automatic logic is_shuffle(input vop_e op);
    is_shuffle = (op == OP_PERMDW) || (op == OP_SLDW) || (op == OP_SPLAT) ||
                 (op == OP_MRGH) || (op == OP_MRGL);
  endfunction
endpackage

// File: rtl/vperm_logic.sv
module vperm_logic
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [2:0]       fn,
  input  logic             sel_mode,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] c,
  output logic [VEC_W-1:0] y
);
  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    assign y[i] = sel_mode ? (c[i] ? b[i] : a[i]) : bit_fn(fn, a[i], b[i]);
  end
endmodule

// File: rtl/vperm_shuffle.sv
module vperm_shuffle
  import vperm_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int VEC_W = WORD_W * LANES
) (
  input  vop_e             op,
  input  logic [1:0]       imm,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] y
);
  logic [WORD_W-1:0] pool [POOL];

  for (genvar k = 0; k < LANES; k++) begin : g_pool
    assign pool[k]         = a[VEC_W-1-k*WORD_W -: WORD_W];
    assign pool[k + LANES] = b[VEC_W-1-k*WORD_W -: WORD_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2:0] idx;
    assign idx = src_word(op, imm, 2'(l));
    assign y[VEC_W-1-l*WORD_W -: WORD_W] = pool[idx];
  end
endmodule

// File: rtl/vperm_outreg.sv
module vperm_outreg #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             suppress,
  input  logic             bad_code,
  input  logic [VEC_W-1:0] next_result,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             unavail_exc,
  output logic             illegal_op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      unavail_exc <= 1'b0;
      illegal_op  <= 1'b0;
    end else begin
      out_valid   <= accept;
      unavail_exc <= accept & suppress;
      illegal_op  <= accept & ~suppress & bad_code;
      if (accept) result <= (suppress || bad_code) ? '0 : next_result;
    end
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int VEC_W = WORD_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             unit_en,
  input  logic [3:0]       op,
  input  logic [1:0]       imm,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic [VEC_W-1:0] opc,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             unavail_exc,
  output logic             illegal_op
);
  vop_e             op_e;
  logic             accept, suppress, bad_code, use_shuffle;
  logic [VEC_W-1:0] logic_y, shuf_y, next_result;

  assign op_e        = vop_e'(op);
  assign accept      = in_valid;
  assign suppress    = ~unit_en;
  assign bad_code    = (op_e == OP_RSV0) || (op_e == OP_RSV1);
  assign use_shuffle = is_shuffle(op_e);

  vperm_logic #(.VEC_W(VEC_W)) u_logic (
    .fn(op[2:0]), .sel_mode(op_e == OP_SEL),
    .a(opa), .b(opb), .c(opc), .y(logic_y)
  );

  vperm_shuffle #(.WORD_W(WORD_W)) u_shuf (
    .op(op_e), .imm(imm), .a(opa), .b(opb), .y(shuf_y)
  );

  assign next_result = use_shuffle ? shuf_y : logic_y;

  vperm_outreg #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .accept(accept), .suppress(suppress),
    .bad_code(bad_code), .next_result(next_result),
    .out_valid(out_valid), .result(result),
    .unavail_exc(unavail_exc), .illegal_op(illegal_op)
  );
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             unit_en,
  input logic [3:0]       op,
  input logic [1:0]       imm,
  input logic [VEC_W-1:0] opa,
  input logic [VEC_W-1:0] opb,
  input logic [VEC_W-1:0] opc,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             unavail_exc,
  input logic             illegal_op
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !unavail_exc && !illegal_op); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_SELECT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && unit_en && op == 4'd13 |=>
      result == (($past(opb) & $past(opc)) | ($past(opa) & ~$past(opc)))); // R4
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && unit_en && op == 4'd9 && imm == 2'd0 |=> result == $past(opa)); // R6
  AST_UNAVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !unit_en |=> unavail_exc && !illegal_op && result == '0); // R9
  AST_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && unit_en && op >= 4'd14 |=> illegal_op && !unavail_exc && result == '0); // R10
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unavail_exc, illegal_op})); // R9
endmodule

bind vperm_unit vperm_unit_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/vperm_unit_test.sv
module vperm_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         unit_en = 1'b0;
  logic [3:0]   op = '0;
  logic [1:0]   imm = '0;
  logic [127:0] opa = '0, opb = '0, opc = '0;
  logic         out_valid, unavail_exc, illegal_op;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  vperm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .unit_en(unit_en),
    .op(op), .imm(imm), .opa(opa), .opb(opb), .opc(opc),
    .out_valid(out_valid), .result(result),
    .unavail_exc(unavail_exc), .illegal_op(illegal_op)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [127:0] rnd128();
    logic [63:0] hi;
    hi = rnd64();
    return {hi, rnd64()};
  endfunction

  function automatic logic [31:0] wd(input logic [127:0] v, input int k);
    return v >> (32 * (3 - k));
  endfunction

  function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] i,
                                         input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c);
    logic [255:0] cat;
    case (o)
      4'd0:  return a & b;
      4'd1:  return a & ~b;
      4'd2:  return a | b;
      4'd3:  return a ^ b;
      4'd4:  return ~(a | b);
      4'd5:  return a ~^ b;
      4'd6:  return ~(a & b);
      4'd7:  return a | ~b;
      4'd8:  return {(i[1] ? a[63:0] : a[127:64]), (i[0] ? b[63:0] : b[127:64])};
      4'd9:  begin cat = {a, b} << (32 * i); return cat[255:128]; end
      4'd10: return {4{wd(b, i)}};
      4'd11: return {wd(a, 0), wd(b, 0), wd(a, 1), wd(b, 1)};
      4'd12: return {wd(a, 2), wd(b, 2), wd(a, 3), wd(b, 3)};
      4'd13: return (b & c) | (a & ~c);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic en);
    if (!en) return "R9";
    case (o)
      4'd8:  return "R5";
      4'd9:  return "R6";
      4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      4'd13: return "R4";
      4'd14, 4'd15: return "R10";
      default: return "R3";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=150000 cycles expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] a, b, c, exp, held;
    string t;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {127'd0, out_valid}, '0);
    chk("R11", result, '0);
    chk("R11", {126'd0, unavail_exc, illegal_op}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 12; v++) begin
      case (v)
        0: begin a = '0; b = '1; c = {4{32'h0000FFFF}}; end
        1: begin a = {32'h00112233, 32'h44556677, 32'h8899AABB, 32'hCCDDEEFF};
                 b = {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210};
                 c = {4{32'hF0F0F0F0}}; end
        2: begin a = '1; b = {64'h5555555555555555, 64'hAAAAAAAAAAAAAAAA}; c = '0; end
        default: begin a = rnd128(); b = rnd128(); c = rnd128(); end
      endcase
      for (int o = 0; o < 16; o++)
        for (int i = 0; i < 4; i++)
          for (int e = 0; e < 2; e++) begin
            in_valid = 1'b1; unit_en = e[0]; op = 4'(o); imm = 2'(i);
            opa = a; opb = b; opc = c;
            @(negedge clk);
            exp = e[0] ? model(4'(o), 2'(i), a, b, c) : '0;
            t = tag_of(4'(o), e[0]);
            chk(t, result, exp);
            chk("R1", {127'd0, out_valid}, 128'd1);
            chk(t, {126'd0, unavail_exc, illegal_op},
                {126'd0, ~e[0], e[0] & (o >= 14)});
            // idle cycle: scramble operands, result must hold (R2)
            held = result;
            in_valid = 1'b0; unit_en = ~unit_en; op = ~op;
            opa = rnd128(); opb = rnd128(); opc = rnd128();
            @(negedge clk);
            chk("R2", result, held);
            chk("R1", {125'd0, out_valid, unavail_exc, illegal_op}, '0);
          end
    end
    summary();
    $finish;
  end
endmodule